// File: doc/BRIEF.md
# BFloat16 Pairwise Dot-Product Accumulator

This block is a vector datapath that treats each 32-bit lane of two source vectors as a pair of BFloat16 values. In every lane it multiplies the two low halves together and the two high halves together, sums the two products, and adds that sum to the single-precision value held in the same lane of an accumulator vector. The result is one single-precision value per lane. Every lane is updated on every operation.

Arithmetic follows a fixed policy. Products of two BFloat16 values are exact in single precision. The two products are added first and rounded. That sum is then added to the accumulator and rounded again, with round to nearest and ties to even. Subnormal operands and subnormal results become zero and keep their sign. Any NaN or invalid operation yields the default quiet NaN. The pipeline takes one new operation per clock and returns its result two clocks later.

Top module: `bfdot_vec`

## Requirements
- R1: The block has VEC_W/32 lanes. Lane e takes its first BFloat16 pair element from bits [32e+15:32e] of each source and its second from bits [32e+31:32e+16]. Its accumulator and its result both occupy bits [32e+31:32e].
- R2: Lane e returns acc + (A_lo·B_lo + A_hi·B_hi). Each product is exact. The inner sum is rounded to single precision first, then added to the accumulator and rounded again. Rounding is to nearest, ties to even.
- R3: The operation is unpredicated. All lanes are computed and written on every accepted operation, each lane independent of the others.
- R4: A BFloat16 value is widened by appending 16 zero bits. A subnormal BFloat16 input or subnormal accumulator (exponent field 0) is treated as a zero with its sign kept.
- R5: A result whose magnitude falls below the smallest normal becomes a zero. The sign is that of the larger operand, and +0 when the addends cancel exactly. A result that overflows, including after rounding, becomes an infinity of the right sign.
- R6: A NaN input (exponent 0xFF, non-zero fraction), infinity times zero, or the sum of opposite infinities gives 0x7FC00000.
- R7: An infinite product or accumulator that is not cancelled by an opposite infinity passes through as an infinity with its own sign.
- R8: out_valid rises exactly two clock edges after an in_valid sample. Back-to-back operations are accepted every cycle, and their results appear on consecutive cycles.
- R9: An active-high synchronous reset clears out_valid and the internal stage valid. An operation still in flight when reset is applied produces no output strobe.
- R10: VEC_W must be a multiple of 32 between 32 and 2048. Any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands on the three vector inputs are valid |
| src_a | input | VEC_W | First source, BFloat16 elements |
| src_b | input | VEC_W | Second source, BFloat16 elements |
| acc_in | input | VEC_W | Accumulator, one fp32 value per lane |
| out_valid | output | 1 | Result vector is valid |
| result | output | VEC_W | Result, one fp32 value per lane |

## Verification
The first stimulus uses small integer-valued operands. Each lane gets different values, with low and high halves chosen so that swapped pairing, swapped lanes or a missing accumulator each give a different number. The rounding patterns use an accumulator of 2^24 or 1.0 plus small products, which separates exact ties, round-up and truncation, and tells rounding to even apart from rounding half away. The special-value patterns cover infinity times zero, opposite infinities, signalling and quiet NaN, overflow past the largest finite value, product underflow and subtractive underflow, and subnormal operands scaled so that a missing flush would become visible. Back-to-back and reset-in-flight sequences check that results and strobes stay aligned.

// File: rtl/bfdot_pkg.sv
package bfdot_pkg;
   localparam int LANE_W    = 32;
   localparam int ELEM_W    = 16;
   localparam int EXP_W     = 8;
   localparam int FRAC_W    = 23;
   localparam int BF_FRAC_W = 7;
   localparam logic [LANE_W-1:0] QNAN_DEF = 32'h7FC0_0000;

   function automatic logic is_nan32(input logic [LANE_W-1:0] v);
      return (v[30:23] == 8'hFF) && (v[22:0] != '0);
   endfunction
endpackage

// File: rtl/bfdot_bf16_mul.sv
module bfdot_bf16_mul
   import bfdot_pkg::*;
(
   input  logic [ELEM_W-1:0] op_x,
   input  logic [ELEM_W-1:0] op_y,
   output logic [LANE_W-1:0] prod
);
   localparam int SIG_W  = BF_FRAC_W + 1;
   localparam int PROD_W = 2 * SIG_W;

   logic             sx, sy, sp;
   logic [EXP_W-1:0] ex, ey;
   logic             x_zero, y_zero, x_inf, y_inf, x_nan, y_nan;
   logic [PROD_W-1:0]   sig_p;
   logic [PROD_W-2:0]   frac_p;
   logic signed [10:0]  exp_p;

   always_comb begin
      sx     = op_x[15];
      sy     = op_y[15];
      sp     = sx ^ sy;
      ex     = op_x[14:7];
      ey     = op_y[14:7];
      x_zero = (ex == '0);
      y_zero = (ey == '0);
      x_inf  = (ex == '1) && (op_x[6:0] == '0);
      y_inf  = (ey == '1) && (op_y[6:0] == '0);
      x_nan  = (ex == '1) && (op_x[6:0] != '0);
      y_nan  = (ey == '1) && (op_y[6:0] != '0);
      sig_p  = {1'b1, op_x[6:0]} * {1'b1, op_y[6:0]};
      exp_p  = 11'({3'b000, ex}) + 11'({3'b000, ey}) - 11'sd127;
      frac_p = '0;
      if (sig_p[PROD_W-1]) begin
         exp_p  = exp_p + 11'sd1;
         frac_p = sig_p[PROD_W-2:0];
      end else begin
         frac_p = {sig_p[PROD_W-3:0], 1'b0};
      end

      if (x_nan || y_nan || (x_inf && y_zero) || (y_inf && x_zero)) begin
         prod = QNAN_DEF;
      end else if (x_inf || y_inf) begin
         prod = {sp, 8'hFF, 23'd0};
      end else if (x_zero || y_zero) begin
         prod = {sp, 31'd0};
      end else if (exp_p > 11'sd254) begin
         prod = {sp, 8'hFF, 23'd0};
      end else if (exp_p < 11'sd1) begin
         prod = {sp, 31'd0};
      end else begin
         prod = {sp, exp_p[7:0], frac_p, {(FRAC_W-PROD_W+1){1'b0}}};
      end
   end
endmodule

// File: rtl/bfdot_fp32_add.sv
module bfdot_fp32_add
   import bfdot_pkg::*;
(
   input  logic [LANE_W-1:0] op_p,
   input  logic [LANE_W-1:0] op_q,
   output logic [LANE_W-1:0] sum
);
   localparam int GRS_W = 3;
   localparam int EXT_W = FRAC_W + 1 + GRS_W;
   localparam int LZ_W  = $clog2(EXT_W + 1);

   logic              p_zero, q_zero, p_inf, q_inf, p_nan, q_nan;
   logic [LANE_W-1:0] big, sml;
   logic [EXP_W-1:0]  dexp;
   logic [EXT_W-1:0]  big_ext, sml_ext, sml_al, norm, mag_diff;
   logic [EXT_W:0]    mag_sum;
   logic [LZ_W-1:0]   lz;
   logic              found, cancel, rnd_up;
   logic [FRAC_W+1:0] sig_r;
   logic signed [10:0] exp_r;

   always_comb begin
      p_zero = (op_p[30:23] == '0);
      q_zero = (op_q[30:23] == '0);
      p_inf  = (op_p[30:23] == '1) && (op_p[22:0] == '0);
      q_inf  = (op_q[30:23] == '1) && (op_q[22:0] == '0);
      p_nan  = is_nan32(op_p);
      q_nan  = is_nan32(op_q);

      if (op_p[30:0] >= op_q[30:0]) begin
         big = op_p;
         sml = op_q;
      end else begin
         big = op_q;
         sml = op_p;
      end
      dexp    = big[30:23] - sml[30:23];
      big_ext = {1'b1, big[22:0], {GRS_W{1'b0}}};
      sml_ext = {1'b1, sml[22:0], {GRS_W{1'b0}}};
      if (32'(dexp) >= EXT_W) begin
         sml_al = EXT_W'(1);
      end else begin
         sml_al = sml_ext >> dexp;
         if ((sml_ext & ((EXT_W'(1) << dexp) - EXT_W'(1))) != '0)
            sml_al[0] = 1'b1;
      end

      mag_sum  = {1'b0, big_ext} + {1'b0, sml_al};
      mag_diff = big_ext - sml_al;
      lz       = '0;
      found    = 1'b0;
      cancel   = 1'b0;
      exp_r    = 11'({3'b000, big[30:23]});
      if (big[31] == sml[31]) begin
         if (mag_sum[EXT_W]) begin
            norm    = mag_sum[EXT_W:1];
            norm[0] = mag_sum[1] | mag_sum[0];
            exp_r   = exp_r + 11'sd1;
         end else begin
            norm = mag_sum[EXT_W-1:0];
         end
      end else begin
         for (int i = EXT_W - 1; i >= 0; i--) begin
            if (!found) begin
               if (mag_diff[i]) found = 1'b1;
               else             lz    = lz + LZ_W'(1);
            end
         end
         cancel = !found;
         norm   = mag_diff << lz;
         exp_r  = exp_r - 11'(lz);
      end

      rnd_up = norm[2] & (norm[1] | norm[0] | norm[3]);
      sig_r  = {1'b0, norm[EXT_W-1:GRS_W]} + (FRAC_W+2)'(rnd_up);
      if (sig_r[FRAC_W+1]) exp_r = exp_r + 11'sd1;

      if (p_nan || q_nan || (p_inf && q_inf && (op_p[31] != op_q[31]))) begin
         sum = QNAN_DEF;
      end else if (p_inf) begin
         sum = {op_p[31], 8'hFF, 23'd0};
      end else if (q_inf) begin
         sum = {op_q[31], 8'hFF, 23'd0};
      end else if (p_zero && q_zero) begin
         sum = {op_p[31] & op_q[31], 31'd0};
      end else if (p_zero) begin
         sum = op_q;
      end else if (q_zero) begin
         sum = op_p;
      end else if (cancel) begin
         sum = '0;
      end else if (exp_r > 11'sd254) begin
         sum = {big[31], 8'hFF, 23'd0};
      end else if (exp_r < 11'sd1) begin
         sum = {big[31], 31'd0};
      end else begin
         sum = {big[31], exp_r[7:0], sig_r[FRAC_W-1:0]};
      end
   end
endmodule

// File: rtl/bfdot_lane.sv
module bfdot_lane
   import bfdot_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic              stg1_en,
   input  logic              stg2_en,
   input  logic              res_vld,
   input  logic [LANE_W-1:0] a_pair,
   input  logic [LANE_W-1:0] b_pair,
   input  logic [LANE_W-1:0] acc,
   output logic [LANE_W-1:0] res
);
   logic [LANE_W-1:0] prod_lo, prod_hi, pair_sum, fin_sum;
   logic [LANE_W-1:0] pair_q, acc_q, res_q;

   bfdot_bf16_mul u_mul_lo (
      .op_x (a_pair[ELEM_W-1:0]),
      .op_y (b_pair[ELEM_W-1:0]),
      .prod (prod_lo)
   );

   bfdot_bf16_mul u_mul_hi (
      .op_x (a_pair[LANE_W-1:ELEM_W]),
      .op_y (b_pair[LANE_W-1:ELEM_W]),
      .prod (prod_hi)
   );

   bfdot_fp32_add u_add_pair (
      .op_p (prod_lo),
      .op_q (prod_hi),
      .sum  (pair_sum)
   );

   always_ff @(posedge clk) begin
      if (stg1_en) begin
         pair_q <= pair_sum;
         acc_q  <= acc;
      end
   end

   bfdot_fp32_add u_add_acc (
      .op_p (acc_q),
      .op_q (pair_q),
      .sum  (fin_sum)
   );

   always_ff @(posedge clk) begin
      if (stg2_en) res_q <= fin_sum;
   end

   assign res = res_q;

   // R5: no subnormal value ever leaves a lane
   a_r5_no_subnormal: assert property (@(posedge clk) disable iff (rst)
      res_vld |-> !((res[30:23] == 8'h00) && (res[22:0] != '0)));

   // R6: every NaN produced is the default quiet NaN
   a_r6_nan_default: assert property (@(posedge clk) disable iff (rst)
      (res_vld && (res[30:23] == 8'hFF) && (res[22:0] != '0)) |-> (res == QNAN_DEF));

   // R6: a NaN accumulator always ends as the default NaN two cycles later
   a_r6_nan_acc: assert property (@(posedge clk) disable iff (rst)
      (stg1_en && is_nan32(acc)) |-> ##2 (res == QNAN_DEF));
endmodule

// File: rtl/bfdot_vec.sv
module bfdot_vec
   import bfdot_pkg::*;
#(
   parameter int VEC_W = 128
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [VEC_W-1:0] src_a,
   input  logic [VEC_W-1:0] src_b,
   input  logic [VEC_W-1:0] acc_in,
   output logic             out_valid,
   output logic [VEC_W-1:0] result
);
   localparam int N_LANE = VEC_W / LANE_W;

   // R10: legal widths only
   if (((VEC_W % LANE_W) != 0) || (VEC_W < LANE_W) || (VEC_W > 2048)) begin : g_bad_width
      initial $fatal(1, "bfdot_vec: VEC_W=%0d must be a multiple of 32 in 32..2048", VEC_W);
   end

   logic vld_s1, vld_s2;

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_s1 <= 1'b0;
         vld_s2 <= 1'b0;
      end else begin
         vld_s1 <= in_valid;
         vld_s2 <= vld_s1;
      end
   end

   assign out_valid = vld_s2;

   for (genvar e = 0; e < N_LANE; e++) begin : g_lane
      bfdot_lane u_lane (
         .clk     (clk),
         .rst     (rst),
         .stg1_en (in_valid),
         .stg2_en (vld_s1),
         .res_vld (vld_s2),
         .a_pair  (src_a [e*LANE_W +: LANE_W]),
         .b_pair  (src_b [e*LANE_W +: LANE_W]),
         .acc     (acc_in[e*LANE_W +: LANE_W]),
         .res     (result[e*LANE_W +: LANE_W])
      );
   end

   // R8: each accepted operation produces a strobe two edges later
   a_r8_latency: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> ##2 out_valid);

   // R8: no strobe without an operation two edges earlier
   a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
      !in_valid |-> ##2 !out_valid);

   // R9: reset clears the output strobe
   a_r9_reset_clears: assert property (@(posedge clk)
      rst |=> !out_valid);
endmodule

// File: tb/bfdot_vec_tb.sv
`timescale 1ns/1ps
module bfdot_vec_tb;
   localparam int VW = 128;
   localparam int NL = VW / 32;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_valid = 1'b0;
   logic [VW-1:0] src_a = '0, src_b = '0, acc_in = '0;
   logic          out_valid;
   logic [VW-1:0] result;

   int n_chk  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   bfdot_vec #(.VEC_W(VW)) u_dut (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .src_a     (src_a),
      .src_b     (src_b),
      .acc_in    (acc_in),
      .out_valid (out_valid),
      .result    (result)
   );

   task automatic check(input logic ok, input string req, input logic [31:0] act,
                        input logic [31:0] expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %08h expected %08h", req, act, expv);
      end
   endtask

   // One operation: drive, confirm no strobe after one edge, sample after two
   task automatic run_op(input string req, input logic [VW-1:0] a, input logic [VW-1:0] b,
                         input logic [VW-1:0] c, input logic [VW-1:0] expv);
      @(negedge clk);
      src_a = a; src_b = b; acc_in = c; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid == 1'b0, {req, " R8 early strobe"}, 32'(out_valid), 32'd0);
      @(negedge clk);
      check(out_valid == 1'b1, {req, " R8 strobe"}, 32'(out_valid), 32'd1);
      for (int e = 0; e < NL; e++)
         check(result[e*32 +: 32] == expv[e*32 +: 32], $sformatf("%s lane%0d", req, e),
               result[e*32 +: 32], expv[e*32 +: 32]);
   endtask

   task automatic t_reset;
      check(out_valid == 1'b0, "R9 reset state", 32'(out_valid), 32'd0);
   endtask

   // R1 R2 R3: integer values, distinct per lane, pairing sensitive
   task automatic t_basic;
      run_op("R1 R2 R3 basic",
         {16'h3F80,16'h3FC0, 16'h3F80,16'hBF80, 16'h3F00,16'h4000, 16'h4000,16'h3F80},
         {16'h0000,16'h4000, 16'h3F80,16'h4040, 16'h4080,16'h4000, 16'h4080,16'h4040},
         {32'hBF800000, 32'h41200000, 32'h00000000, 32'h3F800000},
         {32'h40000000, 32'h41000000, 32'h40C00000, 32'h41400000});
   endtask

   // R2: tie to even (both directions), round up, truncation
   task automatic t_round;
      run_op("R2 rounding",
         {16'h0000,16'h3800, 16'h0000,16'h3FC0, 16'h0000,16'h3FC0, 16'h0000,16'h3F80},
         {16'h0000,16'h3800, 16'h0000,16'h3380, 16'h0000,16'h4000, 16'h0000,16'h3F80},
         {32'h3F800000, 32'h3F800000, 32'h4B800000, 32'h4B800000},
         {32'h3F800000, 32'h3F800001, 32'h4B800002, 32'h4B800000});
   endtask

   // R6 R7: inf*0, opposite infinities, NaN source, negative infinity
   task automatic t_special;
      run_op("R6 R7 specials",
         {16'h3F80,16'hFF80, 16'h0000,16'h7FC1, 16'h3F80,16'h7F80, 16'h0000,16'h7F80},
         {16'h3F80,16'h3F80, 16'h0000,16'h3F80, 16'h3F80,16'h3F80, 16'h0000,16'h0000},
         {32'h40A00000, 32'h3F800000, 32'hFF800000, 32'h00000000},
         {32'hFF800000, 32'h7FC00000, 32'h7FC00000, 32'h7FC00000});
   endtask

   // R4 R5: subnormal operands flushed, product underflow/overflow
   task automatic t_flush;
      run_op("R4 R5 flush",
         {16'h0000,16'h7180, 16'h8000,16'h8D80, 16'h8000,16'h8000, 16'h0000,16'h0040},
         {16'h0000,16'h7180, 16'h3F80,16'h3080, 16'h3F80,16'h3F80, 16'h0000,16'h7180},
         {32'h3F800000, 32'h80000000, 32'h80000005, 32'h00000000},
         {32'h7F800000, 32'h80000000, 32'h80000000, 32'h00000000});
   endtask

   // R5 R6: rounding overflow, exact cancel sign, NaN accumulator, subtractive underflow
   task automatic t_edges;
      run_op("R5 R6 edges",
         {16'h0000,16'h7300, 16'hBF80,16'h3F80, 16'h0000,16'h3F80, 16'h0000,16'hBFC0},
         {16'h0000,16'h3F80, 16'h3F80,16'h3F80, 16'h0000,16'h3F80, 16'h0000,16'h0080},
         {32'h7F7FFFFF, 32'h80000000, 32'h7F800001, 32'h01000000},
         {32'h7F800000, 32'h00000000, 32'h7FC00000, 32'h00000000});
   endtask

   // R8: three operations back to back
   task automatic t_stream;
      logic [31:0] acc_k [3] = '{32'h3F800000, 32'h40000000, 32'h40400000};
      logic [31:0] exp_k [3] = '{32'h40400000, 32'h40800000, 32'h40A00000};
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (i >= 2 && i < 5) begin
            check(out_valid == 1'b1, "R8 stream strobe", 32'(out_valid), 32'd1);
            for (int e = 0; e < NL; e++)
               check(result[e*32 +: 32] == exp_k[i-2], "R8 stream data",
                     result[e*32 +: 32], exp_k[i-2]);
         end else begin
            check(out_valid == 1'b0, "R8 stream idle", 32'(out_valid), 32'd0);
         end
         if (i < 3) begin
            src_a = {NL{32'h3F803F80}};
            src_b = {NL{32'h3F803F80}};
            acc_in = {NL{acc_k[i]}};
            in_valid = 1'b1;
         end else begin
            in_valid = 1'b0;
         end
      end
   endtask

   // R9: reset while an operation is in flight suppresses its strobe
   task automatic t_reset_flight;
      @(negedge clk);
      src_a = {NL{32'h3F803F80}}; src_b = {NL{32'h3F803F80}};
      acc_in = {NL{32'h3F800000}}; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0; rst = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R9 in-flight reset", 32'(out_valid), 32'd0);
      rst = 1'b0;
      @(negedge clk);
      check(out_valid == 1'b0, "R9 after reset", 32'(out_valid), 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst = 1'b0;
      t_basic();
      t_round();
      t_special();
      t_flush();
      t_edges();
      t_stream();
      t_reset_flight();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 10);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule